// File: doc/BRIEF.md
# Compact 16-bit Shift, Add and Immediate Executor

This block executes the first three groups of a dense 16-bit instruction encoding against eight 32-bit general registers and a four-bit condition flag set. The three groups are shift by an immediate amount, three-operand add or subtract, and operations with an 8-bit immediate. The host presents one opcode per cycle with a valid strobe. Each accepted opcode reads its operands from the register bank, computes a result and the negative, zero, carry and overflow flags, and commits the destination register and the flags on the next rising clock edge.

The block decides which group an opcode belongs to from its upper byte alone. The destination index sits in bits [2:0] for the two register groups and in bits [10:8] for the immediate group. Any opcode whose upper byte is 0x40 or above is flagged as not handled here and leaves all state untouched. A combinational read port exposes any register, so an embedding pipeline or a test can observe the bank.

Top module: `short_op_exec`

## Requirements
- R1: After reset all eight registers read 0 and `nzcv` reads 4'b0000, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R2: Upper byte 0x00–0x07 shifts register bits [5:3] left by bits [10:6] into register bits [2:0]. C takes the last bit shifted out, and N and Z follow the result. An amount of 0 copies the value and keeps C.
- R3: Upper bytes 0x08–0x0F (logical) and 0x10–0x17 (arithmetic) shift right by bits [10:6], with C taken from the last bit shifted out. An amount of 0 means a shift by 32: the logical form gives 0 and the arithmetic form gives 32 copies of the sign bit. In both cases C is the source's bit 31.
- R4: Upper bytes 0x18–0x19 write reg[5:3] + reg[8:6] into reg[2:0], and 0x1A–0x1B write reg[5:3] − reg[8:6] into reg[2:0].
- R5: Upper bytes 0x1C–0x1D add and 0x1E–0x1F subtract the 3-bit immediate in bits [8:6], with source reg[5:3] and destination reg[2:0].
- R6: Upper bytes 0x20–0x27 load the zero-extended bits [7:0] into the register named by bits [10:8]. Only N and Z are updated, and C and V keep their values.
- R7: Upper bytes 0x28–0x2F compute reg[10:8] − imm8 and set all four flags, but write no register.
- R8: Upper bytes 0x30–0x37 add imm8 to reg[10:8], and 0x38–0x3F subtract it, writing the result back to the same register.
- R9: For addition, C is the unsigned carry out, and V is set when the operands share a sign that the result does not. For subtraction, C is set when there is no borrow (first operand unsigned ≥ second). V is set when the operand signs differ and the result's sign differs from the first operand's.
- R10: A valid opcode with upper byte 0x40 or above raises `unhandled` in the same cycle and changes neither registers nor flags. Opcodes below 0x40 never raise it. With `op_valid` low, no state changes.
- R11: Register and flag updates become visible only after the rising edge that samples the valid opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Opcode present this cycle |
| opcode | input | 16 | Instruction to execute |
| unhandled | output | 1 | Valid opcode lies outside the three supported groups |
| rd_sel | input | 3 | Register index for the observation port |
| rd_data | output | 32 | Contents of register `rd_sel` |
| nzcv | output | 4 | Flags: N, Z, C, V from bit 3 down to bit 0 |

## Verification
Shifts are tried on a value with both end bits set, so that each amount shows a distinct carry: 1, 2 and 4 for the shifted-out bit, and 0 for the keep-carry and shift-by-32 cases. Add and subtract patterns cover the signed-overflow boundary (0x7FFFFFFF + 1, 0x80000000 − 1), unsigned wrap to zero, and a subtract with borrow against one without, which separates the carry sense and the V rule. Immediate move is run after flags with C and V both set, so that a design clearing them is exposed. Compare is run with a known destination value so that any write is visible. Unhandled and idle opcodes are issued after a known register and flag state is built, so that an update would change a value that is read back.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 8;
  localparam int RIDX   = $clog2(NREG);
  localparam int OPW    = 16;
  localparam int IMMW   = 8;
  localparam int AMTW   = 5;
  localparam int FLAGW  = 4;
  localparam int F_N    = 3;
  localparam int F_Z    = 2;
  localparam int F_C    = 1;
  localparam int F_V    = 0;

  typedef enum logic [1:0] {
    K_SHIFT  = 2'd0,
    K_ADDSUB = 2'd1,
    K_IMM8   = 2'd2,
    K_NONE   = 2'd3
  } kind_e;

  // sub-operation codes, taken straight from opcode bits [12:11]
  localparam logic [1:0] SH_LSL = 2'b00;
  localparam logic [1:0] SH_LSR = 2'b01;
  localparam logic [1:0] SH_ASR = 2'b10;
  localparam logic [1:0] I8_MOV = 2'b00;
  localparam logic [1:0] I8_CMP = 2'b01;
  localparam logic [1:0] I8_ADD = 2'b10;
  localparam logic [1:0] I8_SUB = 2'b11;

  typedef struct packed {
    kind_e               kind;
    logic [1:0]          sub;
    logic                use_imm3;
    logic                is_sub;
    logic [AMTW-1:0]     amt;
    logic [RIDX-1:0]     rd;
    logic [RIDX-1:0]     rs;
    logic [RIDX-1:0]     rn;
    logic [IMMW-1:0]     imm;
  } dec_t;
endpackage

// File: rtl/sx_decode.sv
module sx_decode
  import sx_pkg::*;
(
  input  logic [OPW-1:0] op,
  output dec_t           d
);
  always_comb begin
    d = '0;
    d.kind = K_NONE;
    if (op[15:13] == 3'b000 && op[12:11] != 2'b11) begin
      d.kind = K_SHIFT;
      d.sub  = op[12:11];
      d.amt  = op[10:6];
      d.rs   = op[5:3];
      d.rd   = op[2:0];
    end else if (op[15:11] == 5'b00011) begin
      d.kind     = K_ADDSUB;
      d.use_imm3 = op[10];
      d.is_sub   = op[9];
      d.rn       = op[8:6];
      d.imm      = {{(IMMW-3){1'b0}}, op[8:6]};
      d.rs       = op[5:3];
      d.rd       = op[2:0];
    end else if (op[15:13] == 3'b001) begin
      d.kind = K_IMM8;
      d.sub  = op[12:11];
      d.rd   = op[10:8];
      d.rs   = op[10:8];
      d.imm  = op[7:0];
    end
  end
endmodule

// File: rtl/sx_regfile.sv
module sx_regfile
  import sx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [XLEN-1:0] wd,
  input  logic [RIDX-1:0] ra0,
  input  logic [RIDX-1:0] ra1,
  input  logic [RIDX-1:0] ra2,
  output logic [XLEN-1:0] rd0,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);
  logic [XLEN-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (wa == RIDX'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bank[g] <= '0;
      else if (en) bank[g] <= wd;
    end
  end

  assign rd0 = bank[ra0];
  assign rd1 = bank[ra1];
  assign rd2 = bank[ra2];
endmodule

// File: rtl/sx_alu.sv
module sx_alu
  import sx_pkg::*;
(
  input  dec_t             d,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [FLAGW-1:0] flags_in,
  output logic [XLEN-1:0]  res,
  output logic [FLAGW-1:0] flags_out,
  output logic             wr
);
  localparam int SW = 2*XLEN + 1;

  logic [2*XLEN-1:0] lsl_w;
  logic [SW-1:0]     rsh_w;
  logic [5:0]        rn_amt;
  logic [XLEN-1:0]   ext;
  logic [XLEN-1:0]   b_op, b_eff;
  logic [XLEN:0]     sum;
  logic              do_sub;

  // shifter: left via double width, right via guard bit below lsb
  assign rn_amt = (d.amt == '0) ? 6'd32 : {1'b0, d.amt};
  assign ext    = (d.sub == SH_ASR) ? {XLEN{a[XLEN-1]}} : '0;
  assign lsl_w  = {{XLEN{1'b0}}, a} << d.amt;
  assign rsh_w  = {ext, a, 1'b0} >> rn_amt;

  // adder
  always_comb begin
    if (d.kind == K_IMM8 || d.use_imm3) b_op = {{(XLEN-IMMW){1'b0}}, d.imm};
    else                                b_op = b;
    if (d.kind == K_ADDSUB) do_sub = d.is_sub;
    else                    do_sub = (d.sub == I8_CMP) || (d.sub == I8_SUB);
  end
  assign b_eff = do_sub ? ~b_op : b_op;
  assign sum   = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, do_sub};

  always_comb begin
    flags_out = flags_in;
    res       = sum[XLEN-1:0];
    wr        = 1'b1;
    unique case (d.kind)
      K_SHIFT: begin
        if (d.sub == SH_LSL) begin
          res = lsl_w[XLEN-1:0];
          if (d.amt != '0) flags_out[F_C] = lsl_w[XLEN];
        end else begin
          res            = rsh_w[XLEN:1];
          flags_out[F_C] = rsh_w[0];
        end
      end
      K_ADDSUB, K_IMM8: begin
        if (d.kind == K_IMM8 && d.sub == I8_MOV) begin
          res = b_op;
        end else begin
          flags_out[F_C] = sum[XLEN];
          flags_out[F_V] = (a[XLEN-1] == b_eff[XLEN-1]) && (res[XLEN-1] != a[XLEN-1]);
        end
        wr = !(d.kind == K_IMM8 && d.sub == I8_CMP);
      end
      default: wr = 1'b0;
    endcase
    flags_out[F_N] = res[XLEN-1];
    flags_out[F_Z] = (res == '0);
    if (d.kind == K_NONE) flags_out = flags_in;
  end
endmodule

// File: rtl/short_op_exec.sv
module short_op_exec
  import sx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [OPW-1:0]        opcode,
  output logic                  unhandled,
  input  logic [RIDX-1:0]       rd_sel,
  output logic [XLEN-1:0]       rd_data,
  output logic [FLAGW-1:0]      nzcv
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  dec_t             dec;
  logic [XLEN-1:0]  opa, opb, alu_res;
  logic [FLAGW-1:0] flags_q, flags_d, alu_flags;
  logic             alu_wr, rf_we, flags_en;

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sx_decode u_dec (.op(opcode), .d(dec));

  sx_regfile u_rf (
    .clk(clk), .rst_n(rst_sync_n),
    .we(rf_we), .wa(dec.rd), .wd(alu_res),
    .ra0(dec.rs), .ra1(dec.rn), .ra2(rd_sel),
    .rd0(opa), .rd1(opb), .rd2(rd_data)
  );

  sx_alu u_alu (
    .d(dec), .a(opa), .b(opb), .flags_in(flags_q),
    .res(alu_res), .flags_out(alu_flags), .wr(alu_wr)
  );

  assign unhandled = op_valid && (dec.kind == K_NONE);
  assign flags_en  = op_valid && (dec.kind != K_NONE);
  assign rf_we     = flags_en && alu_wr;

  always_comb begin
    flags_d = flags_q;
    if (flags_en) flags_d = alu_flags;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= '0;
    else             flags_q <= flags_d;
  end

  assign nzcv = flags_q;
endmodule

// File: rtl/sx_chk.sv
module sx_chk
  import sx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OPW-1:0]   opcode,
  input logic             unhandled,
  input logic             rf_we,
  input logic [FLAGW-1:0] flags
);
  // R10
  unh_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && unhandled) |-> !rf_we);
  // R10
  unh_flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && unhandled) |=> $stable(flags));
  // R10
  low_op_handled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[15:14] == 2'b00) |-> !unhandled);
  // R7
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[15:11] == 5'b00101) |-> !rf_we);
  // R6
  mov_cv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[15:11] == 5'b00100) |=> $stable(flags[1:0]));
  // R2
  lsl0_c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[15:6] == 10'd0) |=> $stable(flags[1:0]));
  // R11
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags));
endmodule

bind short_op_exec sx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .unhandled(unhandled), .rf_we(rf_we), .flags(flags_q)
);

// File: tb/short_op_exec_tb.sv
module short_op_exec_tb;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [15:0] opcode;
  logic        unhandled;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;
  logic [3:0]  nzcv;
  int nchk;
  int nerr;
  bit done;

  short_op_exec u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] e_sh(input logic [1:0] k, input int amt, input int rs, input int rd);
    return {3'b000, k, 5'(amt), 3'(rs), 3'(rd)};
  endfunction
  function automatic logic [15:0] e_rr(input bit sub, input int rn, input int rs, input int rd);
    return {5'b00011, 1'b0, sub, 3'(rn), 3'(rs), 3'(rd)};
  endfunction
  function automatic logic [15:0] e_ri(input bit sub, input int im, input int rs, input int rd);
    return {5'b00011, 1'b1, sub, 3'(im), 3'(rs), 3'(rd)};
  endfunction
  function automatic logic [15:0] e_i8(input logic [1:0] k, input int rd, input int im);
    return {3'b001, k, 3'(rd), 8'(im)};
  endfunction

  task automatic exec(input logic [15:0] op);
    @(negedge clk);
    opcode = op; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load(input int r, input logic [31:0] v);
    exec(e_i8(2'b00, r, v[31:24]));
    exec(e_sh(2'b00, 8, r, r)); exec(e_i8(2'b10, r, v[23:16]));
    exec(e_sh(2'b00, 8, r, r)); exec(e_i8(2'b10, r, v[15:8]));
    exec(e_sh(2'b00, 8, r, r)); exec(e_i8(2'b10, r, v[7:0]));
  endtask

  task automatic chk_reg(input string tag, input int r, input logic [31:0] exp);
    rd_sel = 3'(r); #1;
    nchk++;
    if (rd_data !== exp) begin
      nerr++;
      $display("FAIL %s r%0d actual %h expected %h", tag, r, rd_data, exp);
    end
  endtask

  task automatic chk_fl(input string tag, input logic [3:0] exp);
    #1; nchk++;
    if (nzcv !== exp) begin
      nerr++;
      $display("FAIL %s nzcv actual %b expected %b", tag, nzcv, exp);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) chk_reg("R1 reset", i, 32'h0);
    chk_fl("R1 reset", 4'b0000);
  endtask

  task automatic t_imm_ops;
    load(0, 32'h7FFF_FFFF);
    chk_reg("R1 load", 0, 32'h7FFF_FFFF);
    exec(e_i8(2'b10, 0, 1));
    chk_reg("R8 add imm8", 0, 32'h8000_0000); chk_fl("R9 add V", 4'b1001);
    exec(e_i8(2'b11, 0, 1));
    chk_reg("R8 sub imm8", 0, 32'h7FFF_FFFF); chk_fl("R9 sub V C", 4'b0011);
    exec(e_i8(2'b00, 3, 8'h80));
    chk_reg("R6 mov", 3, 32'h80); chk_fl("R6 mov keeps CV", 4'b0011);
    exec(e_i8(2'b00, 3, 0));
    chk_fl("R6 mov zero", 4'b0111);
    exec(e_i8(2'b01, 3, 0));
    chk_fl("R7 cmp equal", 4'b0110); chk_reg("R7 cmp no write", 3, 32'h0);
    exec(e_i8(2'b01, 3, 1));
    chk_fl("R7 cmp borrow", 4'b1000); chk_reg("R7 cmp no write", 3, 32'h0);
  endtask

  task automatic t_shifts;
    load(4, 32'h8000_0001);
    exec(e_sh(2'b00, 1, 4, 5)); chk_reg("R2 lsl1", 5, 32'h2); chk_fl("R2 lsl1", 4'b0010);
    exec(e_sh(2'b00, 0, 4, 6)); chk_reg("R2 lsl0", 6, 32'h8000_0001); chk_fl("R2 lsl0 C kept 1", 4'b1010);
    exec(e_sh(2'b00, 2, 4, 6)); chk_reg("R2 lsl2", 6, 32'h4); chk_fl("R2 lsl2", 4'b0000);
    exec(e_sh(2'b00, 0, 4, 7)); chk_fl("R2 lsl0 C kept 0", 4'b1000);
    exec(e_sh(2'b01, 0, 4, 5)); chk_reg("R3 lsr32", 5, 32'h0); chk_fl("R3 lsr32", 4'b0110);
    exec(e_sh(2'b10, 0, 4, 6)); chk_reg("R3 asr32", 6, 32'hFFFF_FFFF); chk_fl("R3 asr32", 4'b1010);
    exec(e_sh(2'b01, 1, 4, 5)); chk_reg("R3 lsr1", 5, 32'h4000_0000); chk_fl("R3 lsr1", 4'b0010);
    exec(e_sh(2'b10, 4, 4, 6)); chk_reg("R3 asr4", 6, 32'hF800_0000); chk_fl("R3 asr4", 4'b1000);
  endtask

  task automatic t_addsub;
    load(1, 5); load(2, 7);
    exec(e_rr(1'b0, 2, 1, 3)); chk_reg("R4 add", 3, 32'd12); chk_fl("R4 add", 4'b0000);
    exec(e_rr(1'b1, 2, 1, 3)); chk_reg("R4 sub borrow", 3, 32'hFFFF_FFFE); chk_fl("R9 borrow C0", 4'b1000);
    exec(e_rr(1'b1, 1, 2, 3)); chk_reg("R4 sub", 3, 32'd2); chk_fl("R9 no borrow C1", 4'b0010);
    exec(e_ri(1'b0, 7, 1, 3)); chk_reg("R5 add imm3", 3, 32'd12); chk_fl("R5 add imm3", 4'b0000);
    exec(e_ri(1'b1, 5, 1, 3)); chk_reg("R5 sub imm3", 3, 32'd0); chk_fl("R5 sub imm3", 4'b0110);
    exec(e_i8(2'b10, 1, 8'hFF)); chk_reg("R8 add FF", 1, 32'd260); chk_fl("R8 add FF", 4'b0000);
    exec(e_i8(2'b11, 1, 4)); chk_reg("R8 sub 4", 1, 32'd256); chk_fl("R8 sub 4", 4'b0010);
  endtask

  task automatic t_wrap;
    load(2, 32'hFFFF_FFFF); load(3, 1);
    exec(e_rr(1'b0, 3, 2, 4)); chk_reg("R9 wrap", 4, 32'h0); chk_fl("R9 wrap C Z", 4'b0110);
    exec(e_rr(1'b0, 2, 2, 4)); chk_reg("R9 neg+neg", 4, 32'hFFFF_FFFE); chk_fl("R9 neg+neg", 4'b1010);
    load(2, 32'h8000_0000);
    exec(e_rr(1'b1, 3, 2, 4)); chk_reg("R9 sub ovf", 4, 32'h7FFF_FFFF); chk_fl("R9 sub ovf", 4'b0011);
  endtask

  task automatic t_unhandled;
    @(negedge clk); opcode = 16'h4000; op_valid = 1'b1; #1;
    nchk++;
    if (unhandled !== 1'b1) begin nerr++; $display("FAIL R10 unhandled actual %b expected 1", unhandled); end
    @(negedge clk); op_valid = 1'b0;
    chk_reg("R10 no write", 0, 32'h7FFF_FFFF); chk_fl("R10 flags kept", 4'b0011);
    exec(16'hFFFF); chk_reg("R10 no write", 7, 32'h8000_0001); chk_fl("R10 flags kept", 4'b0011);
    @(negedge clk); opcode = 16'h3F00; op_valid = 1'b1; #1;
    nchk++;
    if (unhandled !== 1'b0) begin nerr++; $display("FAIL R10 handled actual %b expected 0", unhandled); end
    opcode = e_i8(2'b00, 0, 0); op_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_reg("R10 idle", 0, 32'h7FFF_FFFF); chk_fl("R10 idle", 4'b0011);
  endtask

  task automatic t_timing;
    @(negedge clk); opcode = e_i8(2'b00, 5, 8'h55); op_valid = 1'b1;
    chk_reg("R11 before edge", 5, 32'h4000_0000);
    @(negedge clk); op_valid = 1'b0;
    chk_reg("R11 after edge", 5, 32'h55); chk_fl("R11 after edge", 4'b0011);
  endtask

  initial begin
    nchk = 0; nerr = 0; done = 1'b0;
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_imm_ops();
    t_shifts();
    t_addsub();
    t_wrap();
    t_unhandled();
    t_timing();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule